// File: doc/BRIEF.md
# RGB LED PWM Generator with Sensor Sample Timer

This block drives the enable inputs of three LED driver channels (red, green, blue) with active-high pulse-width-modulated waveforms of 12-bit resolution. All three channels share one step counter that walks through 4096 duty steps per period. A programmable prescaler stretches each step to (N+1) clocks, where N is an 8-bit setting, so one full period lasts (N+1)×4096 clocks. Each channel output is high while the step count is below that channel's duty value.

Next to the PWM timebase, a second counter produces a single-cycle sample strobe that starts a light-sensor conversion. It fires once every 8×M clocks. M is a 16-bit divisor assembled from a high byte and a low byte. All settings come in as parallel inputs from a register file. Duty values and the prescaler setting are captured only at a period boundary, so a pulse is never cut short or stretched by a write in mid-period. A sleep input freezes every counter and holds all outputs low. Counting then resumes from the frozen point.

Top module: `rgb_pwm_sampler`

## Requirements
- R1: While `rst` is high (synchronous, active high), all three PWM outputs and `sample_strobe` are low, and every counter and captured setting returns to zero.
- R2: Within one period, each channel output is high for exactly duty×(N+1) clocks, where N is the captured `pwm_div` value. The high clocks form one run at the start of the period.
- R3: A duty value of 0 keeps that channel low for the whole period.
- R4: A duty value of 4095 keeps that channel high for all but the last step, which means low for exactly N+1 clocks per period.
- R5: Consecutive period starts, seen as rising edges of a channel with nonzero duty, are exactly (N+1)×4096 clocks apart.
- R6: A new duty value presented in mid-period does not change the current period. It takes effect from the next period start.
- R7: A new `pwm_div` value is captured only at a period start. The step length of the running period does not change.
- R8: With M = {`samp_div_hi`, `samp_div_lo`} (high byte in bits 15:8) nonzero, `sample_strobe` is a one-clock pulse that repeats every 8×M clocks.
- R9: With M = 0, `sample_strobe` stays low.
- R10: While `sleep` is high, all PWM outputs and `sample_strobe` are low and no counter advances. After `sleep` falls, each channel completes its period with the same number of high clocks it would have had with no sleep.
- R11: The three channels are independent. Each one follows its own duty value over the shared timebase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sleep | input | 1 | Freeze all counting and force outputs low |
| duty_red | input | 12 | Red channel duty value |
| duty_green | input | 12 | Green channel duty value |
| duty_blue | input | 12 | Blue channel duty value |
| pwm_div | input | 8 | Step prescaler setting N; each step lasts N+1 clocks |
| samp_div_hi | input | 8 | Upper byte of sample divisor M |
| samp_div_lo | input | 8 | Lower byte of sample divisor M |
| pwm_red | output | 1 | Red LED driver enable, active high |
| pwm_green | output | 1 | Green LED driver enable, active high |
| pwm_blue | output | 1 | Blue LED driver enable, active high |
| sample_strobe | output | 1 | One-clock pulse that starts a sensor conversion |

## Verification
The assertions check on every cycle that the following hold:
- Captured duty values and the captured prescaler change only on a period-start pulse.
- The step counter moves only when a step completes.
- The strobe never lasts two cycles and stays quiet with a zero divisor.
- The strobe counter is frozen during sleep and cleared by reset.

Some properties can only be shown by the bench scenarios, because each one spans thousands of clocks:
- the exact high-clock count per period for several duty/prescaler pairs
- the period length
- the deferral of a mid-period duty write
- the continuity of the high-time count across a sleep interval
- the strobe spacing for divisors that exercise both bytes

// File: rtl/rgb_pwm_pkg.sv
`timescale 1ns/1ps
package rgb_pwm_pkg;

    // Duty resolution, prescaler and sample divisor geometry
    localparam int STEP_W      = 12;
    localparam int PRESC_W     = 8;
    localparam int SDIV_W      = 16;
    localparam int SDIV_SHIFT  = 3;
    localparam int SPAN_W      = SDIV_W + SDIV_SHIFT;
    localparam int NUM_CH      = 3;
    localparam int BYTE_W      = SDIV_W / 2;

    localparam logic [STEP_W-1:0] STEP_MAX = '1;

    typedef enum logic [1:0] {
        CH_RED   = 2'd0,
        CH_GREEN = 2'd1,
        CH_BLUE  = 2'd2
    } chan_e;

    // Shared timebase bundle handed to every channel
    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic              load;
    } tbase_t;

    // Divisor from its two byte halves, high byte first
    function automatic logic [SDIV_W-1:0] join_divisor(
        input logic [BYTE_W-1:0] hi,
        input logic [BYTE_W-1:0] lo
    );
        return {hi, lo};
    endfunction

    // Strobe spacing in clocks: divisor times 2**SDIV_SHIFT
    function automatic logic [SPAN_W-1:0] strobe_span(input logic [SDIV_W-1:0] m);
        return {m, {SDIV_SHIFT{1'b0}}};
    endfunction

endpackage

// File: rtl/pwm_timebase.sv
`timescale 1ns/1ps
module pwm_timebase
    import rgb_pwm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic [PRESC_W-1:0] presc_i,
    output tbase_t             tb_o
);

    logic               primed;
    logic [PRESC_W-1:0] pre_cnt;
    logic [PRESC_W-1:0] pre_q;
    logic [STEP_W-1:0]  step;
    logic               step_done;
    logic               period_done;

    assign step_done   = primed && (pre_cnt == pre_q);
    assign period_done = step_done && (step == STEP_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            primed  <= 1'b0;
            pre_cnt <= '0;
            pre_q   <= '0;
            step    <= '0;
        end else if (run) begin
            if (!primed) begin
                primed <= 1'b1;
                pre_q  <= presc_i;
            end else if (step_done) begin
                pre_cnt <= '0;
                step    <= step + 1'b1;
                if (period_done) begin
                    pre_q <= presc_i;
                end
            end else begin
                pre_cnt <= pre_cnt + 1'b1;
            end
        end
    end

    assign tb_o.step = step;
    assign tb_o.load = run && (!primed || period_done);

    // R5
    step_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (primed && !(run && pre_cnt == pre_q)) |=> (step == $past(step)));

    // R7
    presc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (primed && !tb_o.load) |=> (pre_q == $past(pre_q)));

endmodule

// File: rtl/pwm_channel.sv
`timescale 1ns/1ps
module pwm_channel
    import rgb_pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  tbase_t            tb_i,
    input  logic [STEP_W-1:0] duty_i,
    output logic              pwm_o
);

    logic [STEP_W-1:0] duty_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            duty_q <= '0;
        end else if (tb_i.load) begin
            duty_q <= duty_i;
        end
    end

    assign pwm_o = en && (tb_i.step < duty_q);

    // R6
    duty_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tb_i.load |=> $stable(duty_q));

endmodule

// File: rtl/sample_strobe_gen.sv
`timescale 1ns/1ps
module sample_strobe_gen
    import rgb_pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [SDIV_W-1:0] div_i,
    output logic              strobe_o
);

    logic [SPAN_W-1:0] cnt;
    logic [SPAN_W-1:0] lim;
    logic              strobe_q;

    assign lim = strobe_span(div_i) - 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            strobe_q <= 1'b0;
        end else if (!run) begin
            strobe_q <= 1'b0;
        end else if (div_i == '0) begin
            cnt      <= '0;
            strobe_q <= 1'b0;
        end else if (cnt >= lim) begin
            cnt      <= '0;
            strobe_q <= 1'b1;
        end else begin
            cnt      <= cnt + 1'b1;
            strobe_q <= 1'b0;
        end
    end

    assign strobe_o = strobe_q;

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> ((cnt == '0) && !strobe_q));

    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        strobe_q |=> !strobe_q);

    // R9
    zero_div_chk: assert property (@(posedge clk) disable iff (rst)
        (div_i == '0) |=> !strobe_q);

    // R10
    sleep_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> ($stable(cnt) && !strobe_q));

endmodule

// File: rtl/rgb_pwm_sampler.sv
`timescale 1ns/1ps
module rgb_pwm_sampler
    import rgb_pwm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               sleep,
    input  logic [STEP_W-1:0]  duty_red,
    input  logic [STEP_W-1:0]  duty_green,
    input  logic [STEP_W-1:0]  duty_blue,
    input  logic [PRESC_W-1:0] pwm_div,
    input  logic [BYTE_W-1:0]  samp_div_hi,
    input  logic [BYTE_W-1:0]  samp_div_lo,
    output logic               pwm_red,
    output logic               pwm_green,
    output logic               pwm_blue,
    output logic               sample_strobe
);

    logic              run;
    logic              chan_en;
    tbase_t            tbase;
    logic [STEP_W-1:0] duty_vec [NUM_CH];
    logic [NUM_CH-1:0] pwm_vec;
    logic [SDIV_W-1:0] samp_div;

    assign run     = !sleep;
    assign chan_en = run && !rst;

    assign duty_vec[int'(CH_RED)]   = duty_red;
    assign duty_vec[int'(CH_GREEN)] = duty_green;
    assign duty_vec[int'(CH_BLUE)]  = duty_blue;

    pwm_timebase u_tbase (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .presc_i (pwm_div),
        .tb_o    (tbase)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pwm_channel u_ch (
            .clk    (clk),
            .rst    (rst),
            .en     (chan_en),
            .tb_i   (tbase),
            .duty_i (duty_vec[c]),
            .pwm_o  (pwm_vec[c])
        );
    end

    assign pwm_red   = pwm_vec[int'(CH_RED)];
    assign pwm_green = pwm_vec[int'(CH_GREEN)];
    assign pwm_blue  = pwm_vec[int'(CH_BLUE)];

    assign samp_div = join_divisor(samp_div_hi, samp_div_lo);

    sample_strobe_gen u_samp (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .div_i    (samp_div),
        .strobe_o (sample_strobe)
    );

endmodule

// File: tb/rgb_pwm_sampler_tb_top.sv
`timescale 1ns/1ps
module rgb_pwm_sampler_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        sleep;
    logic [11:0] duty_red, duty_green, duty_blue;
    logic [7:0]  pwm_div, samp_div_hi, samp_div_lo;
    logic        pwm_red, pwm_green, pwm_blue, sample_strobe;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    rgb_pwm_sampler dut_i (
        .clk           (clk),
        .rst           (rst),
        .sleep         (sleep),
        .duty_red      (duty_red),
        .duty_green    (duty_green),
        .duty_blue     (duty_blue),
        .pwm_div       (pwm_div),
        .samp_div_hi   (samp_div_hi),
        .samp_div_lo   (samp_div_lo),
        .pwm_red       (pwm_red),
        .pwm_green     (pwm_green),
        .pwm_blue      (pwm_blue),
        .sample_strobe (sample_strobe)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Find the next period start: red goes from low to high between two samples
    task automatic sync_red();
        logic prev;
        prev = pwm_red;
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk);
            if (!prev && pwm_red) return;
            prev = pwm_red;
        end
        chk("R5", "period start found", 0, 1);
    endtask

    task automatic count_next(input int n, inout int hr, inout int hg, inout int hb);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            hr += int'(pwm_red);
            hg += int'(pwm_green);
            hb += int'(pwm_blue);
        end
    endtask

    task automatic check_rise(input string req);
        logic prev;
        prev = pwm_red;
        @(negedge clk);
        chk(req, "red rises at period boundary", int'(!prev && pwm_red), 1);
    endtask

    // R1: everything low while reset is held
    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "pwm_red in reset", int'(pwm_red), 0);
        chk("R1", "pwm_green in reset", int'(pwm_green), 0);
        chk("R1", "pwm_blue in reset", int'(pwm_blue), 0);
        chk("R1", "strobe in reset", int'(sample_strobe), 0);
        rst = 1'b0;
    endtask

    // R2 R4 R5 R11: three distinct duties, prescaler 0
    task automatic t_basic();
        int hr, hg, hb;
        sync_red();
        hr = int'(pwm_red); hg = int'(pwm_green); hb = int'(pwm_blue);
        count_next(4095, hr, hg, hb);
        chk("R2", "red high clocks", hr, 100);
        chk("R11", "green high clocks", hg, 2048);
        chk("R4", "blue high clocks at 4095", hb, 4095);
        check_rise("R5");
    endtask

    // R6: mid-period duty write deferred to next period
    task automatic t_defer();
        int hr, hg, hb;
        hr = int'(pwm_red); hg = 0; hb = 0;
        count_next(9, hr, hg, hb);
        duty_red = 12'd3000;
        count_next(4086, hr, hg, hb);
        chk("R6", "red high clocks before new duty", hr, 100);
        check_rise("R6");
        hr = int'(pwm_red);
        count_next(4095, hr, hg, hb);
        chk("R6", "red high clocks with new duty", hr, 3000);
    endtask

    // R3 R7 R5: prescaler 2, zero green duty
    task automatic t_prescale();
        int hr, hg, hb;
        duty_red = 12'd300;
        duty_green = 12'd0;
        pwm_div = 8'd2;
        repeat (2) @(negedge clk);
        sync_red();
        hr = int'(pwm_red); hg = int'(pwm_green); hb = int'(pwm_blue);
        count_next(12287, hr, hg, hb);
        chk("R7", "red high clocks with prescaler 2", hr, 900);
        chk("R3", "green high clocks at duty 0", hg, 0);
        chk("R4", "blue high clocks at 4095, prescaler 2", hb, 12285);
        check_rise("R5");
        pwm_div = 8'd0;
    endtask

    // R10: sleep in mid-period freezes counting and holds outputs low
    task automatic t_sleep();
        int hr, hg, hb, bad;
        duty_red = 12'd1000;
        duty_green = 12'd1;
        duty_blue = 12'd0;
        repeat (2) @(negedge clk);
        sync_red();
        sync_red();
        hr = int'(pwm_red); hg = int'(pwm_green); hb = int'(pwm_blue);
        count_next(199, hr, hg, hb);
        sleep = 1'b1;
        bad = 0;
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (pwm_red || pwm_green || pwm_blue || sample_strobe) bad++;
        end
        chk("R10", "active outputs while asleep", bad, 0);
        sleep = 1'b0;
        count_next(3896, hr, hg, hb);
        chk("R10", "red high clocks across sleep", hr, 1000);
        chk("R10", "green high clocks across sleep", hg, 1);
        chk("R10", "blue high clocks across sleep", hb, 0);
        check_rise("R10");
    endtask

    task automatic wait_strobe();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (sample_strobe) return;
        end
        chk("R8", "strobe found", 0, 1);
    endtask

    // R8: strobe spacing for a divisor built from two bytes
    task automatic t_strobe(input logic [7:0] hi, input logic [7:0] lo, input int gap_exp);
        int gap;
        samp_div_hi = hi;
        samp_div_lo = lo;
        wait_strobe();
        for (int k = 0; k < 3; k++) begin
            gap = 0;
            do begin
                @(negedge clk);
                gap++;
            end while (!sample_strobe && gap < 5000);
            chk("R8", "strobe spacing", gap, gap_exp);
        end
    endtask

    // R9: zero divisor silences the strobe
    task automatic t_strobe_off();
        int seen;
        samp_div_hi = 8'd0;
        samp_div_lo = 8'd0;
        seen = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            seen += int'(sample_strobe);
        end
        chk("R9", "strobes with zero divisor", seen, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        sleep = 1'b0;
        duty_red = 12'd100;
        duty_green = 12'd2048;
        duty_blue = 12'd4095;
        pwm_div = 8'd0;
        samp_div_hi = 8'd0;
        samp_div_lo = 8'd5;
        t_reset();
        t_basic();
        t_defer();
        t_prescale();
        t_sleep();
        t_strobe(8'd0, 8'd5, 40);
        t_strobe(8'd1, 8'd0, 2048);
        t_strobe(8'd0, 8'd1, 8);
        t_strobe_off();
        finish_run();
    end

endmodule